// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a register port and the serial shift engine of an SPI controller. Software writes words into a transmit queue, the shift engine drains it one word at a time, and words the engine receives land in a receive queue that software drains by reading. Around the two queues the block keeps the pacing state software needs: fill levels, watermark flags, sticky completion events, a busy indication, an interrupt line and two DMA request lines.

Registers are word-addressed through a single-cycle read/write port with combinational read data. Reading the receive data register also removes that word from the queue. Control writes can enable the block, empty either queue, or return the whole unit to its reset state. The engine side uses valid/ready for transmit words and a valid strobe for receive words. It also has pulse inputs that mark a finished word and a finished frame, and a level input that shows a frame is being shifted.

Top module: `spi_fifo_ctl`

## Requirements
- R1: After reset the control, interrupt-enable, DMA-enable and watermark registers read 0. Both queues are empty. Status reads 0x1 (only the transmit data flag is set). Receive status reads 0x2. irq_o, tx_dma_o and rx_dma_o are 0.
- R2: The parameter register (address 0) reads the log2 transmit depth in bits 3:0 and the log2 receive depth in bits 11:8.
- R3: A write to the transmit data register (address 8) appends a word. Bits 7:0 of FIFO status (address 6) give the transmit word count. A write while the queue is full is discarded.
- R4: A read of the receive data register (address 9) with reg_re_i returns the oldest word and removes it. A read while the queue is empty returns 0. Bit 1 of receive status (address 7) is 1 exactly when the receive queue is empty. An engine word that arrives while the queue is full is discarded.
- R5: Status bit 0 is 1 while the transmit count is at or below the transmit watermark (FIFO control bits starting at 0). Status bit 1 is 1 while the receive count is above the receive watermark (FIFO control bits starting at 16).
- R6: eng_frame_end_i sets status bit 9 and eng_word_done_i sets status bit 10. Both bits stay set until software writes 1 to that bit of status (address 2). Writing 0 leaves them set.
- R7: Status bit 24 follows eng_busy_i.
- R8: irq_o is 1 exactly when some status bit among 0, 1, 9 and 10 is set and the bit at the same position in interrupt enable (address 3) is also set.
- R9: tx_dma_o is DMA-enable bit 0 ANDed with status bit 0. rx_dma_o is DMA-enable bit 1 ANDed with status bit 1 (address 4).
- R10: Writing 1 to control (address 1) bit 8 empties the transmit queue, and writing 1 to bit 9 empties the receive queue. Neither bit is stored, so both read back as 0.
- R11: Control bit 0 enables the block. eng_tx_valid_o is 1 only while the block is enabled and the transmit queue holds a word. eng_tx_data_o shows the oldest word, and eng_tx_ready_i removes it.
- R12: Writing 1 to control bit 1 returns every register, both queues and the sticky flags to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops on receive data) |
| reg_addr_i | input | 4 | Word address |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data, combinational |
| eng_tx_valid_o | output | 1 | Transmit word available to engine |
| eng_tx_data_o | output | DW | Oldest transmit word |
| eng_tx_ready_i | input | 1 | Engine takes the transmit word |
| eng_rx_valid_i | input | 1 | Engine delivers a received word |
| eng_rx_data_i | input | DW | Received word |
| eng_busy_i | input | 1 | Engine is shifting a frame |
| eng_word_done_i | input | 1 | Pulse: one word finished |
| eng_frame_end_i | input | 1 | Pulse: frame finished |
| irq_o | output | 1 | Interrupt request |
| tx_dma_o | output | 1 | Transmit DMA request |
| rx_dma_o | output | 1 | Receive DMA request |

## Verification
The bench writes one word more than the transmit queue holds and pushes one word more than the receive queue holds. A design that wraps its pointers would corrupt the oldest word, or would report a count of zero instead of the depth. It reads from an empty receive queue and expects zero, which catches a design that returns stale data. It steps each fill level across its watermark, where an off-by-one comparison flips a flag one word early. It writes zeros to the sticky bits and checks that they stay set, which catches a clear-on-any-write design. It also checks that a software reset wipes the enables, because a design that leaves them set would keep irq_o or the DMA lines asserted.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  typedef enum logic [3:0] {
    A_PARAM  = 4'd0,
    A_CTRL   = 4'd1,
    A_STAT   = 4'd2,
    A_IEN    = 4'd3,
    A_DEN    = 4'd4,
    A_FCTL   = 4'd5,
    A_FSTAT  = 4'd6,
    A_RSTAT  = 4'd7,
    A_TXDATA = 4'd8,
    A_RXDATA = 4'd9
  } reg_addr_e;

  localparam int B_EN      = 0;
  localparam int B_SRST    = 1;
  localparam int B_TXFLUSH = 8;
  localparam int B_RXFLUSH = 9;

  localparam int B_TDF  = 0;
  localparam int B_RDF  = 1;
  localparam int B_FRM  = 9;
  localparam int B_WRD  = 10;
  localparam int B_BUSY = 24;

  localparam int RXWM_LSB = 16;
endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int W    = 32,
  parameter int LOG2 = 2,
  localparam int DEPTH = 1 << LOG2,
  localparam int CNT_W = LOG2 + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]      mem_q [DEPTH];
  logic [LOG2-1:0]   wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && (cnt_q != FULL_CNT);
  assign pop_ok  = pop_i && !empty_o;
  assign count_o = cnt_q;
  assign rdata_o = empty_o ? '0 : mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= rptr_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !clr_i) mem_q[wptr_q] <= wdata_i;
  end
endmodule

// File: rtl/spi_fifo_sticky.sv
module spi_fifo_sticky #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wipe_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] w1c_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        bit_q <= 1'b0;
      else if (wipe_i)    bit_q <= 1'b0;
      else if (set_i[i])  bit_q <= 1'b1;   // new event beats a same-cycle clear
      else if (w1c_i[i])  bit_q <= 1'b0;
    end
    assign q_o[i] = bit_q;
  end
endmodule

// File: rtl/spi_fifo_ctl.sv
module spi_fifo_ctl
  import spi_fifo_pkg::*;
#(
  parameter int DW      = 32,
  parameter int TX_LOG2 = 2,
  parameter int RX_LOG2 = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          eng_tx_valid_o,
  output logic [DW-1:0] eng_tx_data_o,
  input  logic          eng_tx_ready_i,
  input  logic          eng_rx_valid_i,
  input  logic [DW-1:0] eng_rx_data_i,
  input  logic          eng_busy_i,
  input  logic          eng_word_done_i,
  input  logic          eng_frame_end_i,
  output logic          irq_o,
  output logic          tx_dma_o,
  output logic          rx_dma_o
);
  localparam int TXC_W = TX_LOG2 + 1;
  localparam int RXC_W = RX_LOG2 + 1;
  localparam logic [DW-1:0] IEN_MASK =
      DW'((1 << B_TDF) | (1 << B_RDF) | (1 << B_FRM) | (1 << B_WRD));

  logic              en_q;
  logic [DW-1:0]     ien_q;
  logic [1:0]        den_q;
  logic [TXC_W-1:0]  tx_wm_q, tx_cnt;
  logic [RXC_W-1:0]  rx_wm_q, rx_cnt;
  logic              tx_empty, rx_empty;
  logic [DW-1:0]     rx_head;
  logic [1:0]        evt_q;
  logic [DW-1:0]     stat_v;
  logic              tdf, rdf;

  logic wr_ctrl, wr_stat, srst;
  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_stat = reg_we_i && (reg_addr_i == A_STAT);
  assign srst    = wr_ctrl && reg_wdata_i[B_SRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      ien_q   <= '0;
      den_q   <= '0;
      tx_wm_q <= '0;
      rx_wm_q <= '0;
    end else if (srst) begin
      en_q    <= 1'b0;
      ien_q   <= '0;
      den_q   <= '0;
      tx_wm_q <= '0;
      rx_wm_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_CTRL: en_q  <= reg_wdata_i[B_EN];
        A_IEN:  ien_q <= reg_wdata_i & IEN_MASK;
        A_DEN:  den_q <= reg_wdata_i[1:0];
        A_FCTL: begin
          tx_wm_q <= reg_wdata_i[TXC_W-1:0];
          rx_wm_q <= reg_wdata_i[RXWM_LSB +: RXC_W];
        end
        default: ;
      endcase
    end
  end

  spi_fifo_buf #(.W(DW), .LOG2(TX_LOG2)) u_txq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wr_ctrl && (reg_wdata_i[B_TXFLUSH] || reg_wdata_i[B_SRST])),
    .push_i  (reg_we_i && (reg_addr_i == A_TXDATA)),
    .wdata_i (reg_wdata_i),
    .pop_i   (eng_tx_valid_o && eng_tx_ready_i),
    .rdata_o (eng_tx_data_o),
    .count_o (tx_cnt),
    .empty_o (tx_empty)
  );

  spi_fifo_buf #(.W(DW), .LOG2(RX_LOG2)) u_rxq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wr_ctrl && (reg_wdata_i[B_RXFLUSH] || reg_wdata_i[B_SRST])),
    .push_i  (eng_rx_valid_i),
    .wdata_i (eng_rx_data_i),
    .pop_i   (reg_re_i && (reg_addr_i == A_RXDATA)),
    .rdata_o (rx_head),
    .count_o (rx_cnt),
    .empty_o (rx_empty)
  );

  spi_fifo_sticky #(.N(2)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wipe_i (srst),
    .set_i  ({eng_word_done_i, eng_frame_end_i}),
    .w1c_i  ({wr_stat && reg_wdata_i[B_WRD], wr_stat && reg_wdata_i[B_FRM]}),
    .q_o    (evt_q)
  );

  assign tdf = (tx_cnt <= tx_wm_q);
  assign rdf = (rx_cnt > rx_wm_q);

  always_comb begin
    stat_v         = '0;
    stat_v[B_TDF]  = tdf;
    stat_v[B_RDF]  = rdf;
    stat_v[B_FRM]  = evt_q[0];
    stat_v[B_WRD]  = evt_q[1];
    stat_v[B_BUSY] = eng_busy_i;
  end

  assign eng_tx_valid_o = en_q && !tx_empty;
  assign irq_o    = |(stat_v & ien_q);
  assign tx_dma_o = den_q[0] && tdf;
  assign rx_dma_o = den_q[1] && rdf;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_PARAM: begin
        reg_rdata_o[3:0]  = 4'(TX_LOG2);
        reg_rdata_o[11:8] = 4'(RX_LOG2);
      end
      A_CTRL:   reg_rdata_o[B_EN] = en_q;
      A_STAT:   reg_rdata_o = stat_v;
      A_IEN:    reg_rdata_o = ien_q;
      A_DEN:    reg_rdata_o[1:0] = den_q;
      A_FCTL: begin
        reg_rdata_o[TXC_W-1:0]          = tx_wm_q;
        reg_rdata_o[RXWM_LSB +: RXC_W]  = rx_wm_q;
      end
      A_FSTAT:  reg_rdata_o[TXC_W-1:0] = tx_cnt;
      A_RSTAT:  reg_rdata_o[1] = rx_empty;
      A_RXDATA: reg_rdata_o = rx_head;
      default:  ;
    endcase
  end
endmodule

// File: rtl/spi_fifo_ctl_chk.sv
module spi_fifo_ctl_chk #(
  parameter int DW      = 32,
  parameter int TX_LOG2 = 2,
  parameter int RX_LOG2 = 2,
  localparam int TXC_W = TX_LOG2 + 1,
  localparam int RXC_W = RX_LOG2 + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic             reg_re_i,
  input logic [3:0]       reg_addr_i,
  input logic [DW-1:0]    reg_wdata_i,
  input logic [DW-1:0]    reg_rdata_o,
  input logic             eng_tx_valid_o,
  input logic             eng_tx_ready_i,
  input logic             eng_busy_i,
  input logic [TXC_W-1:0] tx_cnt,
  input logic [RXC_W-1:0] rx_cnt
);
  localparam logic [TXC_W-1:0] TX_FULL = TXC_W'(1 << TX_LOG2);
  localparam logic [RXC_W-1:0] RX_FULL = RXC_W'(1 << RX_LOG2);

  assert_tx_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= TX_FULL);

  assert_rx_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= RX_FULL);

  assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 4'd8 && tx_cnt == TX_FULL &&
     !(eng_tx_valid_o && eng_tx_ready_i)) |=> tx_cnt == TX_FULL);

  assert_empty_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i == 4'd9 && rx_cnt == '0) |-> reg_rdata_o == '0);

  assert_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 4'd1 && reg_wdata_i[8]) |=> tx_cnt == '0);

  assert_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 4'd2) |-> reg_rdata_o[24] == eng_busy_i);

  assert_txvalid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_tx_valid_o |-> tx_cnt != '0);
endmodule

bind spi_fifo_ctl spi_fifo_ctl_chk #(
  .DW(DW), .TX_LOG2(TX_LOG2), .RX_LOG2(RX_LOG2)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_we_i       (reg_we_i),
  .reg_re_i       (reg_re_i),
  .reg_addr_i     (reg_addr_i),
  .reg_wdata_i    (reg_wdata_i),
  .reg_rdata_o    (reg_rdata_o),
  .eng_tx_valid_o (eng_tx_valid_o),
  .eng_tx_ready_i (eng_tx_ready_i),
  .eng_busy_i     (eng_busy_i),
  .tx_cnt         (tx_cnt),
  .rx_cnt         (rx_cnt)
);

// File: tb/spi_fifo_ctl_bench.sv
`timescale 1ns/1ps
module spi_fifo_ctl_bench;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic          tx_valid, tx_ready = 1'b0;
  logic [DW-1:0] tx_data;
  logic          rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          busy = 1'b0, word_done = 1'b0, frame_end = 1'b0;
  logic          irq, tx_dma, rx_dma;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  spi_fifo_ctl u_spi_fifo_ctl (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .eng_tx_valid_o(tx_valid), .eng_tx_data_o(tx_data), .eng_tx_ready_i(tx_ready),
    .eng_rx_valid_i(rx_valid), .eng_rx_data_i(rx_data),
    .eng_busy_i(busy), .eng_word_done_i(word_done), .eng_frame_end_i(frame_end),
    .irq_o(irq), .tx_dma_o(tx_dma), .rx_dma_o(rx_dma)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pop_rx(output logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'd9; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic push_rx(input logic [31:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic pulse_word();
    @(negedge clk); word_done = 1'b1;
    @(negedge clk); word_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    peek(4'd1, v); check("R1 ctrl", v, 0);
    peek(4'd2, v); check("R1 status", v, 32'h1);
    peek(4'd7, v); check("R1 rx status", v, 32'h2);
    peek(4'd6, v); check("R1 fifo status", v, 0);
    peek(4'd3, v); check("R1 irq enable", v, 0);
    check("R1 outputs", {29'd0, irq, tx_dma, rx_dma}, 0);
  endtask

  task automatic t_param();
    logic [31:0] v;
    peek(4'd0, v); check("R2 param", v, 32'h0202);
  endtask

  task automatic t_tx();
    logic [31:0] v;
    for (int i = 0; i < 5; i++) wr(4'd8, 32'hA1 + i);
    peek(4'd6, v); check("R3 count at full", v, 4);
    check("R11 no valid while disabled", {31'd0, tx_valid}, 0);
    wr(4'd1, 32'h1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1 check("R11 valid", {31'd0, tx_valid}, 1);
      check("R3 order, 5th dropped", tx_data, 32'hA1 + i);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
    #1 check("R11 valid after drain", {31'd0, tx_valid}, 0);
    peek(4'd6, v); check("R3 count drained", v, 0);
    wr(4'd1, 32'h0);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    for (int i = 0; i < 5; i++) push_rx(32'hB1 + i);
    peek(4'd7, v); check("R4 rx not empty", v, 0);
    for (int i = 0; i < 4; i++) begin
      pop_rx(v); check("R4 rx order", v, 32'hB1 + i);
    end
    pop_rx(v); check("R4 empty read zero", v, 0);
    peek(4'd7, v); check("R4 rx empty", v, 32'h2);
  endtask

  task automatic t_wm();
    logic [31:0] v;
    wr(4'd5, 32'h0001_0002);
    peek(4'd5, v); check("R5 fifo ctrl readback", v, 32'h0001_0002);
    wr(4'd8, 1); wr(4'd8, 2);
    peek(4'd2, v); check("R5 tdf at watermark", v & 3, 32'h1);
    wr(4'd8, 3);
    peek(4'd2, v); check("R5 tdf above watermark", v & 1, 0);
    push_rx(7);
    peek(4'd2, v); check("R5 rdf at watermark", v & 2, 0);
    push_rx(8);
    peek(4'd2, v); check("R5 rdf above watermark", v & 2, 32'h2);
    wr(4'd1, 32'h100);
    peek(4'd6, v); check("R10 tx flushed", v, 0);
    peek(4'd1, v); check("R10 flush bit not stored", v, 0);
    peek(4'd7, v); check("R10 rx untouched", v, 0);
    wr(4'd1, 32'h200);
    peek(4'd7, v); check("R10 rx flushed", v, 32'h2);
    wr(4'd5, 0);
  endtask

  task automatic t_flags();
    logic [31:0] v;
    pulse_frame();
    peek(4'd2, v); check("R6 frame flag", v, 32'h201);
    wr(4'd2, 0);
    peek(4'd2, v); check("R6 write zero keeps", v, 32'h201);
    pulse_word();
    peek(4'd2, v); check("R6 word flag", v, 32'h601);
    wr(4'd2, 32'h200);
    peek(4'd2, v); check("R6 clear frame only", v, 32'h401);
    wr(4'd2, 32'h400);
    peek(4'd2, v); check("R6 clear word", v, 32'h1);
    busy = 1'b1;
    peek(4'd2, v); check("R7 busy bit", v, 32'h0100_0001);
    busy = 1'b0;
    peek(4'd2, v); check("R7 busy low", v, 32'h1);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(4'd3, 32'h200);
    #1 check("R8 enabled but no event", {31'd0, irq}, 0);
    pulse_frame();
    #1 check("R8 frame irq", {31'd0, irq}, 1);
    wr(4'd2, 32'h200);
    #1 check("R8 irq cleared", {31'd0, irq}, 0);
    wr(4'd3, 32'h1);
    #1 check("R8 tdf irq", {31'd0, irq}, 1);
    wr(4'd8, 32'h55);
    #1 check("R8 tdf drops irq", {31'd0, irq}, 0);
    wr(4'd1, 32'h100);
    wr(4'd3, 0);
    peek(4'd3, v); check("R8 ien readback", v, 0);
  endtask

  task automatic t_dma();
    logic [31:0] v;
    wr(4'd4, 32'h1);
    #1 check("R9 tx dma", {30'd0, tx_dma, rx_dma}, 32'h2);
    wr(4'd4, 32'h2);
    #1 check("R9 rx dma idle", {30'd0, tx_dma, rx_dma}, 0);
    push_rx(32'h99);
    #1 check("R9 rx dma req", {30'd0, tx_dma, rx_dma}, 32'h1);
    pop_rx(v);
    #1 check("R9 rx dma after pop", {31'd0, rx_dma}, 0);
    wr(4'd4, 0);
  endtask

  task automatic t_srst();
    logic [31:0] v;
    wr(4'd3, 32'h603); wr(4'd4, 32'h3); wr(4'd5, 32'h0001_0001);
    wr(4'd8, 1); wr(4'd8, 2); push_rx(3); pulse_frame();
    wr(4'd1, 32'h2);
    peek(4'd1, v); check("R12 ctrl", v, 0);
    peek(4'd3, v); check("R12 ien", v, 0);
    peek(4'd4, v); check("R12 den", v, 0);
    peek(4'd5, v); check("R12 fifo ctrl", v, 0);
    peek(4'd6, v); check("R12 tx count", v, 0);
    peek(4'd7, v); check("R12 rx empty", v, 32'h2);
    peek(4'd2, v); check("R12 status", v, 32'h1);
    check("R12 outputs", {28'd0, tx_valid, irq, tx_dma, rx_dma}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_param();
    t_tx();
    t_rx();
    t_wm();
    t_flags();
    t_irq();
    t_dma();
    t_srst();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule